// File: doc/BRIEF.md
# Microstepping Step/Direction Indexer

This block turns a step-and-direction command stream into current setpoints for the two windings of a bipolar stepper motor. It keeps a position index that covers one full electrical cycle with 128 positions. Each qualifying STEP edge moves the index by a stride chosen by the resolution input, forward or backward as DIR says. From the index the block looks up a quarter-wave sine magnitude for each winding and scales it by a 3-bit torque code. It then registers a signed setpoint and a polarity bit per winding for the current-regulation stage further down the chip.

The inputs are expected to be synchronised and deglitched already. The active-low output enable only silences the setpoints, and the index keeps following STEP and DIR while the outputs are off. Sleep holds the index at its home position, 45 degrees electrical, where both windings carry the same current. A change of resolution takes effect at the next qualifying edge. At that edge the index first snaps to the nearest position that is valid for the new resolution, and only then takes the step.

Top module: `stepper_indexer`

## Requirements
- R1: While rst_n is low, both setpoints and both polarity bits are 0, and the index is set to home, position 16 (45 degrees). One clock after release, with the outputs enabled and torque code 0, both setpoints read +176.
- R2: res_sel selects the step stride in index units: 0 gives full step (32), 1 half (16), 2 quarter (8), 3 eighth (4), 4 sixteenth (2), and 5 or above 1/32 step (1). The index wraps modulo 128.
- R3: dir_in is sampled at the qualifying edge. A value of 1 adds the stride to the index and 0 subtracts it.
- R4: A rising STEP edge always qualifies. A falling edge qualifies only when dual_edge is 1 and res_sel is 3 or above. Any other falling edge leaves the index and the outputs unchanged.
- R5: At each qualifying edge the index is first rounded to the nearest valid position for the sampled resolution, with ties rounded upward, and then stepped. In full step the valid positions are 16+32m. In the other modes they are the multiples of the stride.
- R6: For index p, winding B takes magnitude round(31*|sin(2*pi*p/128)|) and winding A takes the same function at p+32. A winding's polarity bit is 1 when its angle lies in [64,127], and this includes zero-magnitude points.
- R7: The setpoint magnitude is the table value times (8 - torque), so code 0 gives 100% and code 7 gives 12.5%. The setpoint is negative when the polarity bit is 1.
- R8: out_en_n = 1 forces both setpoints and both polarity bits to 0 one clock later. STEP and DIR keep moving the index during that time.
- R9: sleep_n = 0 holds the index at home, ignores STEP and forces the outputs to 0. A STEP level that is already high when sleep ends does not count as an edge.
- R10: The setpoints reflect a STEP transition two clocks after it appears at the input. They reflect a change of torque, out_en_n or sleep_n one clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Low parks the index at home and turns the outputs off |
| out_en_n | input | 1 | High forces the setpoints to zero |
| step_in | input | 1 | Step command level |
| dir_in | input | 1 | Step direction, 1 = increasing index |
| res_sel | input | 3 | Resolution code |
| dual_edge | input | 1 | Allows falling edges to advance in eighth step and finer |
| torque | input | 3 | Current scale code, 0 = 100%, 7 = 12.5% |
| a_set | output | 9 | Winding A signed setpoint |
| a_neg | output | 1 | Winding A polarity |
| b_set | output | 9 | Winding B signed setpoint |
| b_neg | output | 1 | Winding B polarity |

## Verification
A STEP transition passes through two registers, the edge-detect/index stage and the output stage. Its effect on the setpoints is therefore due two clocks later. Torque, enable and sleep pass through only the output register and are due after one clock. The bench drives every input on the falling clock edge and compares all four outputs against a behavioural model on every falling edge, where the due cycle has already been counted. The latency check confirms that the old setpoints are still present one clock after a step and the new ones after two.

// File: rtl/stepper_indexer_pkg.sv
`timescale 1ns/1ps
package stepper_indexer_pkg;

   // quarter-wave resolution the table is built for
   localparam int TABLE_RES  = 5;
   localparam int TABLE_BITS = 5;

   // round(31 * sin(j * pi / 64)), j = 0 .. 32
   function automatic logic [TABLE_BITS-1:0] sine_quarter(input int j);
      logic [TABLE_BITS-1:0] v;
      case (j)
         0:  v = 5'd0;   1:  v = 5'd2;   2:  v = 5'd3;   3:  v = 5'd5;
         4:  v = 5'd6;   5:  v = 5'd8;   6:  v = 5'd9;   7:  v = 5'd10;
         8:  v = 5'd12;  9:  v = 5'd13;  10: v = 5'd15;  11: v = 5'd16;
         12: v = 5'd17;  13: v = 5'd18;  14: v = 5'd20;  15: v = 5'd21;
         16: v = 5'd22;  17: v = 5'd23;  18: v = 5'd24;  19: v = 5'd25;
         20: v = 5'd26;  21: v = 5'd27;  22: v = 5'd27;  23: v = 5'd28;
         24: v = 5'd29;  25: v = 5'd29;  26: v = 5'd30;  27: v = 5'd30;
         28: v = 5'd30;  29: v = 5'd31;  30: v = 5'd31;  31: v = 5'd31;
         default: v = 5'd31;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/step_edge_qual.sv
`timescale 1ns/1ps
module step_edge_qual #(
   parameter int RES_W    = 3,
   parameter int FINE_MIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dual_edge,
   input  logic [RES_W-1:0] res_sel,
   output logic             qual
);

   logic step_q;
   logic rise, fall, fine_mode;

   // previous level is tracked at all times so a level held across sleep is no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= 1'b0;
      else        step_q <= step_in;
   end

   always_comb begin
      rise      = step_in & ~step_q;
      fall      = ~step_in & step_q;
      fine_mode = (res_sel >= RES_W'(FINE_MIN));
      qual      = rise | (fall & dual_edge & fine_mode);
   end

   // R4
   rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_in && !$past(step_in)) |-> qual);

endmodule

// File: rtl/step_position.sv
`timescale 1ns/1ps
module step_position #(
   parameter int MAX_RES = 5,
   parameter int RES_W   = 3,
   localparam int POS_W  = MAX_RES + 2,
   localparam int HOME   = 1 << (MAX_RES - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_n,
   input  logic             qual,
   input  logic             dir_in,
   input  logic [RES_W-1:0] res_sel,
   output logic [POS_W-1:0] pos
);

   localparam logic [POS_W-1:0] HOME_POS  = POS_W'(HOME);
   localparam logic [POS_W-1:0] QTR_MASK  = POS_W'((1 << MAX_RES) - 1);

   logic [RES_W-1:0] res_eff;
   logic [POS_W-1:0] stride, snap_mask, rounded, nxt;

   always_comb begin
      res_eff   = (res_sel > RES_W'(MAX_RES)) ? RES_W'(MAX_RES) : res_sel;
      stride    = POS_W'(1) << (RES_W'(MAX_RES) - res_eff);
      snap_mask = ~(stride - POS_W'(1));
      if (res_eff == '0)
         rounded = (pos & ~QTR_MASK) | HOME_POS;
      else
         rounded = (pos + (stride >> 1)) & snap_mask;
      nxt = dir_in ? (rounded + stride) : (rounded - stride);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= HOME_POS;
      else if (!sleep_n) pos <= HOME_POS;
      else if (qual)    pos <= nxt;
   end

   // R3
   step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && qual) |=> (pos != $past(pos)));
   // R2
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && !qual) |=> (pos == $past(pos)));
   // R9
   sleep_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (pos == HOME_POS));
   // R5
   full_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && qual && res_sel == '0) |=> ((pos & QTR_MASK) == HOME_POS));

endmodule

// File: rtl/winding_drive.sv
`timescale 1ns/1ps
module winding_drive
   import stepper_indexer_pkg::*;
#(
   parameter int MAX_RES = 5,
   parameter int MAG_W   = 5,
   parameter int TRQ_W   = 3,
   parameter int PHASE   = 0,
   localparam int POS_W  = MAX_RES + 2,
   localparam int PROD_W = MAG_W + TRQ_W,
   localparam int SET_W  = PROD_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    drive_on,
   input  logic [POS_W-1:0]        pos,
   input  logic [TRQ_W-1:0]        torque,
   output logic signed [SET_W-1:0] set_q,
   output logic                    neg_q
);

   logic [POS_W-1:0]   angle;
   logic [MAX_RES-1:0] frac;
   logic [MAX_RES:0]   tbl_idx;
   logic [MAG_W-1:0]   mag;
   logic [TRQ_W:0]     scale;
   logic [PROD_W-1:0]  prod;
   logic signed [SET_W-1:0] signed_val;

   always_comb begin
      angle   = pos + POS_W'(PHASE);
      frac    = angle[MAX_RES-1:0];
      // second and fourth quarters read the table backwards
      tbl_idx = angle[MAX_RES] ? ((MAX_RES+1)'(1 << MAX_RES) - {1'b0, frac})
                               : {1'b0, frac};
      mag     = MAG_W'(sine_quarter(int'(tbl_idx)));
      scale   = (TRQ_W+1)'(1 << TRQ_W) - {1'b0, torque};
      prod    = PROD_W'(mag) * PROD_W'(scale);
      signed_val = angle[POS_W-1] ? -$signed({1'b0, prod}) : $signed({1'b0, prod});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q <= '0;
         neg_q <= 1'b0;
      end else if (!drive_on) begin
         set_q <= '0;
         neg_q <= 1'b0;
      end else begin
         set_q <= signed_val;
         neg_q <= angle[POS_W-1];
      end
   end

   // R8
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_on |=> (set_q == '0 && !neg_q));
   // R7
   full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_on && torque == '0 && $stable(pos)) |=>
         (set_q <= $signed(SET_W'(31 << TRQ_W)) && set_q >= -$signed(SET_W'(31 << TRQ_W))));

endmodule

// File: rtl/stepper_indexer.sv
`timescale 1ns/1ps
module stepper_indexer #(
   parameter int MAX_RES  = 5,
   parameter int RES_W    = 3,
   parameter int MAG_W    = 5,
   parameter int TRQ_W    = 3,
   parameter int FINE_MIN = 3,
   localparam int POS_W   = MAX_RES + 2,
   localparam int SET_W   = MAG_W + TRQ_W + 1,
   localparam int QTR     = 1 << MAX_RES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sleep_n,
   input  logic                    out_en_n,
   input  logic                    step_in,
   input  logic                    dir_in,
   input  logic [RES_W-1:0]        res_sel,
   input  logic                    dual_edge,
   input  logic [TRQ_W-1:0]        torque,
   output logic signed [SET_W-1:0] a_set,
   output logic                    a_neg,
   output logic signed [SET_W-1:0] b_set,
   output logic                    b_neg
);

   // elaboration-time parameter checks
   if (MAX_RES != stepper_indexer_pkg::TABLE_RES || MAG_W != stepper_indexer_pkg::TABLE_BITS)
   begin : g_bad_table
      $error("sine table is built for MAX_RES=5 and MAG_W=5");
   end
   if ((1 << RES_W) <= MAX_RES) begin : g_bad_res_w
      $error("RES_W too narrow for MAX_RES");
   end
   if (FINE_MIN > MAX_RES) begin : g_bad_fine
      $error("FINE_MIN above MAX_RES");
   end

   logic             qual;
   logic             drive_on;
   logic [POS_W-1:0] pos;
   logic signed [SET_W-1:0] set_arr [2];
   logic                    neg_arr [2];

   always_comb drive_on = sleep_n & ~out_en_n;

   step_edge_qual #(.RES_W(RES_W), .FINE_MIN(FINE_MIN)) u_edge (
      .clk(clk), .rst_n(rst_n), .step_in(step_in), .dual_edge(dual_edge),
      .res_sel(res_sel), .qual(qual));

   step_position #(.MAX_RES(MAX_RES), .RES_W(RES_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .qual(qual),
      .dir_in(dir_in), .res_sel(res_sel), .pos(pos));

   // winding 0 (A) leads by a quarter cycle, winding 1 (B) follows the index
   for (genvar w = 0; w < 2; w++) begin : g_wind
      winding_drive #(
         .MAX_RES(MAX_RES), .MAG_W(MAG_W), .TRQ_W(TRQ_W),
         .PHASE((w == 0) ? QTR : 0)
      ) u_wind (
         .clk(clk), .rst_n(rst_n), .drive_on(drive_on), .pos(pos),
         .torque(torque), .set_q(set_arr[w]), .neg_q(neg_arr[w]));
   end

   always_comb begin
      a_set = set_arr[0];
      a_neg = neg_arr[0];
      b_set = set_arr[1];
      b_neg = neg_arr[1];
   end

   // R9
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (a_set == '0 && b_set == '0 && !a_neg && !b_neg));

endmodule

// File: tb/stepper_indexer_bench.sv
`timescale 1ns/1ps
module stepper_indexer_bench;
   logic clk = 1'b0, rst_n = 1'b0, sleep_n = 1'b1, out_en_n = 1'b0;
   logic step_in = 1'b0, dir_in = 1'b1, dual_edge = 1'b0;
   logic [2:0] res_sel = 3'd5, torque = 3'd0;
   logic signed [8:0] a_set, b_set;
   logic a_neg, b_neg;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit done = 1'b0;
   int m_idx = 16, m_a = 0, m_b = 0;
   bit m_an = 1'b0, m_bn = 1'b0, m_sq = 1'b0;

   stepper_indexer u_stepper_indexer (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .out_en_n(out_en_n),
      .step_in(step_in), .dir_in(dir_in), .res_sel(res_sel), .dual_edge(dual_edge),
      .torque(torque), .a_set(a_set), .a_neg(a_neg), .b_set(b_set), .b_neg(b_neg));

   always #4 clk = ~clk;

   function automatic int wrap(input int x);
      return ((x % 128) + 128) % 128;
   endfunction

   function automatic int mag_of(input int ang);
      real v;
      v = $sin(2.0 * 3.14159265358979 * real'(wrap(ang)) / 128.0);
      if (v < 0.0) v = -v;
      return int'($floor(31.0 * v + 0.5));
   endfunction

   function automatic int setp(input int ang, input int t);
      int m;
      m = mag_of(ang) * (8 - t);
      return (wrap(ang) >= 64) ? -m : m;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_idx = 16; m_a = 0; m_b = 0; m_an = 0; m_bn = 0; m_sq = 0;
      end else begin
         int re, s, base;
         bit q;
         if (!sleep_n || out_en_n) begin
            m_a = 0; m_b = 0; m_an = 0; m_bn = 0;
         end else begin
            m_a  = setp(m_idx + 32, int'(torque));
            m_b  = setp(m_idx, int'(torque));
            m_an = wrap(m_idx + 32) >= 64;
            m_bn = wrap(m_idx) >= 64;
         end
         re = (res_sel > 3'd5) ? 5 : int'(res_sel);
         q  = (step_in && !m_sq) || (!step_in && m_sq && dual_edge && re >= 3);
         if (!sleep_n) m_idx = 16;
         else if (q) begin
            s = 32 >> re;
            if (re == 0) base = (m_idx / 32) * 32 + 16;
            else         base = wrap(((m_idx + s / 2) / s) * s);
            m_idx = wrap(dir_in ? base + s : base - s);
         end
         m_sq = step_in;
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(cur_req, int'(a_set), m_a);
         chk(cur_req, int'(b_set), m_b);
         chk(cur_req, int'(a_neg), int'(m_an));
         chk(cur_req, int'(b_neg), int'(m_bn));
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input bit d);
      @(negedge clk);
      dir_in = d; step_in = 1'b1;
      wait_n(3);
      step_in = 1'b0;
      wait_n(3);
   endtask

   task automatic chk_ab(input string req, input int ea, input int eb);
      chk(req, int'(a_set), ea);
      chk(req, int'(b_set), eb);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait_n(3);
      cur_req = "R1";
      chk_ab("R1", 0, 0);
      chk("R1", int'(a_neg), 0);
      rst_n = 1'b1;
      wait_n(2);
      chk_ab("R1", 176, 176);

      // R10 latency: old value after one clock, new after two
      cur_req = "R10";
      dir_in = 1'b1; step_in = 1'b1;
      wait_n(1);
      chk_ab("R10", 176, 176);
      wait_n(1);
      chk_ab("R10", 168, 184);
      step_in = 1'b0;
      wait_n(3);

      // R3 direction, finest mode
      cur_req = "R3";
      for (int i = 0; i < 4; i++) pulse(1'b1);
      chk_ab("R3", 128, 216);
      pulse(1'b0); pulse(1'b0); pulse(1'b1); pulse(1'b1);
      chk_ab("R3", 128, 216);

      // R5 snap to full-step grid then step: 21 -> 16 -> 48
      cur_req = "R5";
      res_sel = 3'd0;
      pulse(1'b1);
      chk_ab("R5", -176, 176);
      chk("R5", int'(a_neg), 1);

      // R6 half step back to 32: winding A at zero with negative polarity
      cur_req = "R6";
      res_sel = 3'd1;
      pulse(1'b0);
      chk_ab("R6", 0, 248);
      chk("R6", int'(a_neg), 1);
      chk("R6", int'(b_neg), 0);

      // R4 dual edge in eighth step: two edges, 32 -> 40
      cur_req = "R4";
      res_sel = 3'd3; dual_edge = 1'b1;
      pulse(1'b1);
      chk_ab("R4", -96, 232);

      // R4 quarter step: falling edge ignored even with dual_edge set
      res_sel = 3'd2;
      @(negedge clk); dir_in = 1'b1; step_in = 1'b1;
      wait_n(3);
      chk_ab("R4", -176, 176);
      step_in = 1'b0;
      wait_n(3);
      chk_ab("R4", -176, 176);

      // R2 wrap below zero in full step: 48 -> 16 -> 112
      cur_req = "R2";
      res_sel = 3'd0; dual_edge = 1'b0;
      pulse(1'b0); pulse(1'b0);
      chk_ab("R2", 176, -176);
      chk("R2", int'(b_neg), 1);

      // R7 torque sweep, one clock latency
      cur_req = "R7";
      for (int t = 0; t < 8; t++) begin
         torque = 3'(t);
         wait_n(1);
         chk_ab("R7", 22 * (8 - t), -22 * (8 - t));
      end
      torque = 3'd0;
      wait_n(1);

      // R8 outputs off while the index keeps moving: 112 -> 16 -> 48
      cur_req = "R8";
      out_en_n = 1'b1;
      wait_n(1);
      chk_ab("R8", 0, 0);
      chk("R8", int'(b_neg), 0);
      pulse(1'b1); pulse(1'b1);
      chk_ab("R8", 0, 0);
      out_en_n = 1'b0;
      wait_n(1);
      chk_ab("R8", -176, 176);

      // R9 sleep: home, steps ignored, held-high level at wake is no edge
      cur_req = "R9";
      sleep_n = 1'b0;
      wait_n(1);
      chk_ab("R9", 0, 0);
      pulse(1'b1); pulse(1'b1);
      chk_ab("R9", 0, 0);
      step_in = 1'b1;
      wait_n(2);
      sleep_n = 1'b1;
      wait_n(2);
      chk_ab("R9", 176, 176);
      step_in = 1'b0;
      wait_n(3);
      chk_ab("R9", 176, 176);

      // R2 finest with both edges, then code 7 acting as finest
      cur_req = "R2";
      res_sel = 3'd5; dual_edge = 1'b1;
      pulse(1'b1);
      chk_ab("R2", 160, 192);
      res_sel = 3'd7; dual_edge = 1'b0;
      pulse(1'b0);
      chk_ab("R2", 168, 184);

      wait_n(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule